// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent 32-bit timers behind a simple register bus made of an address, write data, a write strobe, a read strobe and read data. Each timer owns a 64-byte window. The address bits above bit 5 select the timer, and the low six bits select a register inside its window. An enabled timer counts down on every clock. In external mode it counts down only on clocks where the shared `tick_i` input is high. When it steps from zero it reloads from its reload register. A step that lands on zero, or on either of two match values, raises a sticky status bit if the timer's interrupt enable is on. That status bit drives the timer's interrupt line.

The four control bits of a timer are never written directly. Software writes ones to a set port or to a clear port, and a small per-timer sequencer applies them over the next two cycles in a fixed order. A set writes the configuration bits first and the enable bit last. A clear removes the enable bit first and the configuration bits after it. As a result the counter never runs with a half-applied configuration. The interrupt status is read in the same control word and is cleared through the clear port.

The sequencer has five states. In SEQ_IDLE it accepts a control write: a set write moves it to SEQ_SET_CFG, a clear write moves it to SEQ_CLR_DIS, and no write keeps it in SEQ_IDLE. SEQ_SET_CFG applies the pending configuration bits and always moves to SEQ_SET_EN. SEQ_SET_EN applies a pending enable and returns to SEQ_IDLE. SEQ_CLR_DIS removes a pending enable and always moves to SEQ_CLR_CFG. SEQ_CLR_CFG removes the pending configuration bits and returns to SEQ_IDLE.

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, reload, match and control register is 0, every status bit and `irq_o` bit is 0, and `rdata_o` is 0.
- R2: In a timer's window, offset 0x00 is the live count, 0x04 the reload value, 0x08 match A and 0x0C match B. All four are 32-bit read/write. Read data is registered: it appears on `rdata_o` in the cycle after `rd_en_i` is sampled, and `rdata_o` is 0 in any cycle that follows no read.
- R3: A read of offset 0x10 returns the control bits in bits [3:0] and the status in bit 16; every other bit reads 0. The control bit positions are enable = bit 0, external tick = bit 1, interrupt enable = bit 2 and pulse enable = bit 3.
- R4: A write to offset 0x10 sets the written-1 control bits that are currently 0. The configuration bits (1 to 3) become visible one cycle after the write edge, and enable becomes visible one cycle later.
- R5: A write to offset 0x14 clears the written-1 control bits. Enable is removed one cycle after the write edge, and the configuration bits are removed one cycle later.
- R6: A set or clear write that reaches a timer while its sequencer is outside SEQ_IDLE leaves its control bits unchanged.
- R7: Bit 16 of a write to offset 0x10 has no effect. Bit 16 of a write to offset 0x14 clears that timer's status at the write edge, whatever the sequencer state.
- R8: An enabled timer steps on every clock when the external tick bit is 0, and only on clocks with `tick_i` high when it is 1. A step from 0 loads the reload value; any other step subtracts 1. A disabled timer holds its count. A bus write to the count register takes priority over a step.
- R9: A step whose new count is 0, match A or match B sets the status bit when interrupt enable is 1, and sets nothing otherwise. `irq_o[i]` equals timer i's status bit and stays high until the status is cleared. A setting step wins over a clear in the same cycle.
- R10: An access whose timer index (address bits above bit 5) is 8 or more, or whose offset is 0x14 on a read or anything from 0x18 to 0x3C, reads 0 and is ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle external count tick shared by all timers |
| addr_i | input | 10 | Byte address: timer index in [9:6], register offset in [5:0] |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 8 | Per-timer interrupt, equal to that timer's status bit |

## Verification
The assertions assume that the bus presents at most one access per cycle and that `tick_i` is a clean synchronous level. They also assume that software does not depend on a control write issued during the two sequencing cycles. The stimulus respects all of this. Every bus operation takes exactly one cycle and is driven at the falling edge. Each control write is followed by at least two quiet cycles before the next one, except in the one directed case that deliberately writes during sequencing to show it is dropped. External ticks are single-cycle pulses spaced apart and are issued only while no control write is pending.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control bit positions inside one timer's control nibble
    localparam int CTL_EN    = 0;
    localparam int CTL_EXT   = 1;
    localparam int CTL_IRQ   = 2;
    localparam int CTL_PULSE = 3;
    localparam int CTL_BITS  = 4;

    // Status bit position in the control word
    localparam int STS_BIT = 16;

    // Register offsets inside a 64-byte timer window
    localparam int OFS_W = 6;
    localparam logic [OFS_W-1:0] OFS_COUNT   = 6'h00;
    localparam logic [OFS_W-1:0] OFS_RELOAD  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_MATCH_A = 6'h08;
    localparam logic [OFS_W-1:0] OFS_MATCH_B = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_CTL_SET = 6'h10;
    localparam logic [OFS_W-1:0] OFS_CTL_CLR = 6'h14;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SET_CFG,
        SEQ_SET_EN,
        SEQ_CLR_DIS,
        SEQ_CLR_CFG
    } seq_state_e;

endpackage

// File: rtl/tmr_ctl_seq.sv
module tmr_ctl_seq
    import tmr_pkg::*;
#(
    parameter int CW = CTL_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_wr_i,
    input  logic          clr_wr_i,
    input  logic [CW-1:0] wmask_i,
    output logic [CW-1:0] ctrl_o
);

    localparam logic [CW-1:0] EN_MASK  = CW'(1) << CTL_EN;
    localparam logic [CW-1:0] CFG_MASK = ~EN_MASK;

    seq_state_e    state_q, state_d;
    logic [CW-1:0] ctrl_q;
    logic [CW-1:0] pend_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (set_wr_i)      state_d = SEQ_SET_CFG;
                else if (clr_wr_i) state_d = SEQ_CLR_DIS;
            end
            SEQ_SET_CFG: state_d = SEQ_SET_EN;
            SEQ_SET_EN:  state_d = SEQ_IDLE;
            SEQ_CLR_DIS: state_d = SEQ_CLR_CFG;
            SEQ_CLR_CFG: state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: pending mask and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (set_wr_i)      pend_q <= wmask_i & ~ctrl_q;
                    else if (clr_wr_i) pend_q <= wmask_i & ctrl_q;
                end
                SEQ_SET_CFG: ctrl_q <= ctrl_q | (pend_q & CFG_MASK);
                SEQ_SET_EN:  ctrl_q <= ctrl_q | (pend_q & EN_MASK);
                SEQ_CLR_DIS: ctrl_q <= ctrl_q & ~(pend_q & EN_MASK);
                SEQ_CLR_CFG: ctrl_q <= ctrl_q & ~(pend_q & CFG_MASK);
                default: begin
                    ctrl_q <= ctrl_q;
                end
            endcase
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [CTL_BITS-1:0] ctrl_i,
    input  logic [CNT_W-1:0]    wdata_i,
    input  logic                wr_cnt_i,
    input  logic                wr_reload_i,
    input  logic                wr_ma_i,
    input  logic                wr_mb_i,
    input  logic                clr_sts_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [CNT_W-1:0]    reload_o,
    output logic [CNT_W-1:0]    ma_o,
    output logic [CNT_W-1:0]    mb_o,
    output logic                sts_o
);

    logic [CNT_W-1:0] cnt_q, reload_q, ma_q, mb_q;
    logic             sts_q;
    logic             step;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    // ctrl_i[CTL_PULSE] is stored by the sequencer and read back; it
    // has no effect on counting.
    logic unused_pulse;
    assign unused_pulse = ctrl_i[CTL_PULSE];

    assign step    = ctrl_i[CTL_EN] && (ctrl_i[CTL_EXT] ? tick_i : 1'b1);
    assign cnt_nxt = (cnt_q == '0) ? reload_q : cnt_q - CNT_W'(1);
    assign hit     = step && ctrl_i[CTL_IRQ] &&
                     ((cnt_nxt == '0) || (cnt_nxt == ma_q) || (cnt_nxt == mb_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            ma_q     <= '0;
            mb_q     <= '0;
        end else begin
            if (wr_cnt_i)   cnt_q <= wdata_i;
            else if (step)  cnt_q <= cnt_nxt;
            if (wr_reload_i) reload_q <= wdata_i;
            if (wr_ma_i)     ma_q     <= wdata_i;
            if (wr_mb_i)     mb_q     <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sts_q <= 1'b0;
        else if (hit)       sts_q <= 1'b1;
        else if (clr_sts_i) sts_q <= 1'b0;
    end

    assign cnt_o    = cnt_q;
    assign reload_o = reload_q;
    assign ma_o     = ma_q;
    assign mb_o     = mb_q;
    assign sts_o    = sts_q;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NCH-1:0]    irq_o
);

    localparam int CH_IDX_W = ADDR_W - OFS_W;
    localparam int IDX_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CH_IDX_W:0] NCH_L = (CH_IDX_W+1)'(NCH);

    logic [CH_IDX_W-1:0] ch_idx;
    logic [OFS_W-1:0]    ofs;
    logic                in_range;
    logic [IDX_W-1:0]    sel_idx;

    assign ch_idx   = addr_i[ADDR_W-1:OFS_W];
    assign ofs      = addr_i[OFS_W-1:0];
    assign in_range = ({1'b0, ch_idx} < NCH_L);
    assign sel_idx  = ch_idx[IDX_W-1:0];

    logic [CTL_BITS-1:0] ctrl_a   [NCH];
    logic [CNT_W-1:0]    cnt_a    [NCH];
    logic [CNT_W-1:0]    reload_a [NCH];
    logic [CNT_W-1:0]    ma_a     [NCH];
    logic [CNT_W-1:0]    mb_a     [NCH];
    logic [NCH-1:0]      sts_a;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic wr_here;
        assign wr_here = wr_en_i && in_range && (ch_idx == CH_IDX_W'(i));

        tmr_ctl_seq #(.CW(CTL_BITS)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_wr_i (wr_here && (ofs == OFS_CTL_SET)),
            .clr_wr_i (wr_here && (ofs == OFS_CTL_CLR)),
            .wmask_i  (wdata_i[CTL_BITS-1:0]),
            .ctrl_o   (ctrl_a[i])
        );

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .ctrl_i      (ctrl_a[i]),
            .wdata_i     (wdata_i[CNT_W-1:0]),
            .wr_cnt_i    (wr_here && (ofs == OFS_COUNT)),
            .wr_reload_i (wr_here && (ofs == OFS_RELOAD)),
            .wr_ma_i     (wr_here && (ofs == OFS_MATCH_A)),
            .wr_mb_i     (wr_here && (ofs == OFS_MATCH_B)),
            .clr_sts_i   (wr_here && (ofs == OFS_CTL_CLR) && wdata_i[STS_BIT]),
            .cnt_o       (cnt_a[i]),
            .reload_o    (reload_a[i]),
            .ma_o        (ma_a[i]),
            .mb_o        (mb_a[i]),
            .sts_o       (sts_a[i])
        );
    end

    // Read multiplexer
    logic [DATA_W-1:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (in_range) begin
            unique case (ofs)
                OFS_COUNT:   rd_val = DATA_W'(cnt_a[sel_idx]);
                OFS_RELOAD:  rd_val = DATA_W'(reload_a[sel_idx]);
                OFS_MATCH_A: rd_val = DATA_W'(ma_a[sel_idx]);
                OFS_MATCH_B: rd_val = DATA_W'(mb_a[sel_idx]);
                OFS_CTL_SET: begin
                    rd_val[CTL_BITS-1:0] = ctrl_a[sel_idx];
                    rd_val[STS_BIT]      = sts_a[sel_idx];
                end
                default: rd_val = '0;
            endcase
        end
    end

    logic [DATA_W-1:0] rdata_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_en_i ? rd_val : '0;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = sts_a;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic                wr_en_i,
    input logic                rd_en_i,
    input logic [DATA_W-1:0]   rdata_o,
    input logic [NCH-1:0]      irq_o,
    input logic [CTL_BITS-1:0] ch_ctrl [NCH],
    input logic [CNT_W-1:0]    ch_cnt  [NCH]
);

    localparam int CH_IDX_W = ADDR_W - OFS_W;
    localparam logic [CH_IDX_W:0] NCH_L = (CH_IDX_W+1)'(NCH);

    logic oob;
    assign oob = ({1'b0, addr_i[ADDR_W-1:OFS_W]} >= NCH_L);

    // R10: a read outside the timer range returns zero
    p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && oob) |=> (rdata_o == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic wr_cnt_here, clr_sts_here;
        assign wr_cnt_here  = wr_en_i && (addr_i[ADDR_W-1:OFS_W] == CH_IDX_W'(i)) &&
                              (addr_i[OFS_W-1:0] == OFS_COUNT);
        assign clr_sts_here = wr_en_i && (addr_i[ADDR_W-1:OFS_W] == CH_IDX_W'(i)) &&
                              (addr_i[OFS_W-1:0] == OFS_CTL_CLR) && wdata_i[STS_BIT];

        // R9: interrupt only rises while interrupt enable was on
        p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[i]) |-> $past(ch_ctrl[i][CTL_IRQ]));

        // R4: enable is applied after configuration, never together
        p_enable_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ctrl[i][CTL_EN]) |-> $stable(ch_ctrl[i][CTL_BITS-1:1]));

        // R5: disable comes first, configuration is untouched that cycle
        p_disable_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_ctrl[i][CTL_EN]) |-> $stable(ch_ctrl[i][CTL_BITS-1:1]));

        // R7: status stays set unless the clear port is written with bit 16
        p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[i] && !clr_sts_here) |=> irq_o[i]);

        // R8: a disabled timer without a count write keeps its count
        p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[i][CTL_EN] && !wr_cnt_here) |=> $stable(ch_cnt[i]));
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .ch_ctrl (ctrl_a),
    .ch_cnt  (cnt_a)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;

    localparam logic [5:0] O_CNT = 6'h00, O_RLD = 6'h04, O_MA = 6'h08,
                           O_MB = 6'h0C, O_SET = 6'h10, O_CLR = 6'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [9:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rdata_o;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [9:0] adr(input int ch, input logic [5:0] o);
        return 10'(ch * 64) | 10'(o);
    endfunction

    // Expected count after a number of steps (R8)
    function automatic logic [31:0] f_count(input logic [31:0] s, input logic [31:0] r,
                                            input int steps);
        logic [31:0] c = s;
        for (int k = 0; k < steps; k++) c = (c == 0) ? r : c - 1;
        return c;
    endfunction

    // Expected status after a number of steps (R9)
    function automatic logic f_hit(input logic [31:0] s, input logic [31:0] r,
                                   input logic [31:0] ma, input logic [31:0] mb,
                                   input int steps, input logic ie);
        logic [31:0] c = s;
        logic h = 1'b0;
        for (int k = 0; k < steps; k++) begin
            c = (c == 0) ? r : c - 1;
            if (c == 0 || c == ma || c == mb) h = 1'b1;
        end
        return h && ie;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [5:0] o, input logic [31:0] d);
        addr_i = adr(ch, o); wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [5:0] o, output logic [31:0] d);
        addr_i = adr(ch, o); rd_en_i = 1'b1;
        @(negedge clk);
        d = rdata_o; rd_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Load, run for k steps with the timer enabled, stop, then check
    task automatic run_trial(input int ch, input logic [31:0] s, input logic [31:0] r,
                             input logic [31:0] ma, input logic [31:0] mb,
                             input int k, input logic ie);
        logic [31:0] d;
        logic        es;
        wr(ch, O_CNT, s); wr(ch, O_RLD, r); wr(ch, O_MA, ma); wr(ch, O_MB, mb);
        wr(ch, O_CLR, 32'h0001_000F); idle(3);
        wr(ch, O_SET, ie ? 32'h5 : 32'h1);
        idle(k);
        wr(ch, O_CLR, ie ? 32'h5 : 32'h1);
        idle(3);
        es = f_hit(s, r, ma, mb, k, ie);
        rd(ch, O_SET, d);
        chk("R9 status in control word", d, {15'd0, es, 16'd0});
        chk("R9 irq output", {31'd0, irq_o[ch]}, {31'd0, es});
        rd(ch, O_CNT, d);
        chk("R8 count after steps", d, f_count(s, r, k));
    endtask

    initial begin
        logic [31:0] d, r0, r1, r2;
        void'($urandom(32'h1234_5678));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 rdata after reset", rdata_o, 32'h0);
        chk("R1 irq after reset", {24'd0, irq_o}, 32'h0);
        rd(0, O_CNT, d);  chk("R1 count after reset", d, 32'h0);
        rd(3, O_SET, d);  chk("R1 control after reset", d, 32'h0);
        rd(7, O_RLD, d);  chk("R1 reload after reset", d, 32'h0);

        // R2 register read/write
        wr(5, O_RLD, 32'hA5A5_1234); wr(5, O_MA, 32'h0000_1111);
        wr(5, O_MB, 32'hDEAD_BEEF);  wr(7, O_CNT, 32'h0BAD_F00D);
        rd(5, O_RLD, d); chk("R2 reload readback", d, 32'hA5A5_1234);
        rd(5, O_MA, d);  chk("R2 match A readback", d, 32'h0000_1111);
        rd(5, O_MB, d);  chk("R2 match B readback", d, 32'hDEAD_BEEF);
        rd(7, O_CNT, d); chk("R2 count readback", d, 32'h0BAD_F00D);
        idle(1);
        chk("R2 rdata zero without read", rdata_o, 32'h0);

        // R10 out-of-range index and undefined offsets
        wr(8, O_CNT, 32'h55);
        rd(0, O_CNT, d); chk("R10 index 8 write ignored", d, 32'h0);
        rd(8, O_CNT, d); chk("R10 index 8 reads zero", d, 32'h0);
        wr(5, 6'h18, 32'hFFFF_FFFF);
        rd(5, O_RLD, d); chk("R10 undefined offset write ignored", d, 32'hA5A5_1234);
        rd(5, 6'h18, d); chk("R10 undefined offset reads zero", d, 32'h0);
        rd(5, O_CLR, d); chk("R10 clear port reads zero", d, 32'h0);

        // R4 set ordering, R3 layout (external tick held low)
        wr(2, O_CNT, 32'd50);
        wr(2, O_SET, 32'hF);
        rd(2, O_SET, r0); rd(2, O_SET, r1); rd(2, O_SET, r2);
        chk("R4 nothing applied at write edge", r0, 32'h0);
        chk("R4 configuration before enable", r1, 32'hE);
        chk("R3 all control bits at [3:0]", r2, 32'hF);

        // R8 external tick mode
        idle(5);
        rd(2, O_CNT, d); chk("R8 external mode holds without tick", d, 32'd50);
        for (int p = 0; p < 3; p++) begin
            tick_i = 1'b1; @(negedge clk); tick_i = 1'b0; @(negedge clk);
        end
        rd(2, O_CNT, d); chk("R8 one step per tick", d, 32'd47);

        // R5 clear ordering
        wr(2, O_CLR, 32'hF);
        rd(2, O_SET, r0); rd(2, O_SET, r1); rd(2, O_SET, r2);
        chk("R5 nothing removed at write edge", r0, 32'hF);
        chk("R5 enable removed first", r1, 32'hE);
        chk("R5 configuration removed second", r2, 32'h0);
        idle(4);
        rd(2, O_CNT, d); chk("R8 disabled timer holds", d, 32'd47);

        // R6 control write during sequencing is dropped
        wr(4, O_SET, 32'h4);
        wr(4, O_SET, 32'h8);
        idle(3);
        rd(4, O_SET, d); chk("R6 busy write ignored", d, 32'h4);
        wr(4, O_SET, 32'h2); idle(3);
        rd(4, O_SET, d); chk("R4 set keeps existing bits", d, 32'h6);
        wr(4, O_CLR, 32'h6); idle(3);

        // R8/R9 directed counting cases
        run_trial(6, 32'd3, 32'd10, 32'd40, 32'd40, 5, 1'b1);  // reaches zero
        rd(6, O_SET, d); chk("R9 status sticky after stop", d, 32'h0001_0000);
        wr(6, O_CLR, 32'h0001_0000); idle(1);
        rd(6, O_SET, d); chk("R7 clear port bit 16 clears status", d, 32'h0);
        chk("R7 irq low after clear", {31'd0, irq_o[6]}, 32'h0);
        wr(6, O_SET, 32'h0001_0000); idle(3);
        rd(6, O_SET, d); chk("R7 set port bit 16 has no effect", d, 32'h0);
        chk("R7 irq stays low", {31'd0, irq_o[6]}, 32'h0);
        run_trial(1, 32'd3, 32'd10, 32'd0, 32'd0, 6, 1'b0);    // interrupt off
        run_trial(0, 32'd2, 32'd5, 32'd99, 32'd99, 5, 1'b1);   // reload path
        run_trial(3, 32'd20, 32'd0, 32'd15, 32'd99, 5, 1'b1);  // match A
        run_trial(3, 32'd20, 32'd0, 32'd14, 32'd13, 5, 1'b1);  // no hit
        run_trial(3, 32'd20, 32'd0, 32'd99, 32'd17, 3, 1'b1);  // match B

        // Random trials
        for (int t = 0; t < 40; t++) begin
            run_trial($urandom_range(7, 0), $urandom_range(40, 0), $urandom_range(30, 0),
                      $urandom_range(45, 0), $urandom_range(45, 0),
                      $urandom_range(60, 2), 1'($urandom_range(1, 0)));
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule